// File: doc/BRIEF.md
# Idle Mode Power Controller

This block sequences a CPU core into and out of a low-power idle state. A power-save strobe arrives together with a mode selector. When the selector asks for idle, the controller takes the CPU clock enable away, and the system clock keeps running so that peripherals continue to work. It pulses a clear to the watchdog as it enters. While idle it watches three wake sources: enabled interrupt requests, a device reset request and a watchdog timeout. When one of them fires, it gives the clock back and reports the cause. It also tells the core whether to resume at the instruction after the power-save instruction or at the interrupt handler.

The controller has four states. RUN is normal execution. ENTERING is a single cycle in which the watchdog is cleared. IDLE lasts until a wake source fires. WAKE is a single cycle that reports the cause. The transitions are as follows. RUN goes to ENTERING on a strobe with the idle selector. ENTERING always goes to IDLE. IDLE goes to WAKE when a wake request is present. WAKE always returns to RUN. An enabled interrupt that arrives with the strobe, or during ENTERING, is latched as pending. It then forces IDLE to WAKE after exactly one IDLE cycle, so it is neither lost nor allowed to abort entry. A reset request that arrives in the same window is latched in the same way.

Top module: `idle_power_ctrl`

## Requirements
- R1: From RUN, a strobe with `pwrsav_mode`=1 (idle) is followed by one ENTERING cycle and then IDLE. `idle_active` is 1 only in IDLE. `cpu_clk_en` is 0 in ENTERING and IDLE and 1 in RUN and WAKE.
- R2: `wdt_clear` is 1 for exactly the one ENTERING cycle and 0 at all other times.
- R3: A strobe with `pwrsav_mode`=0 (sleep) is ignored by this block: the controller stays in RUN.
- R4: In IDLE, a line i with both `irq_flag[i]` and `irq_en[i]` set causes WAKE on the next cycle. A flag whose enable is clear never causes a wake.
- R5: In IDLE, `dev_reset` or `wdt_timeout` causes WAKE on the next cycle. `wake_cause` is one-hot: bit 0 is interrupt, bit 1 is reset, bit 2 is watchdog. The order of precedence is reset, then watchdog, then interrupt. `wake_valid` and `wake_cause` are nonzero only in the single WAKE cycle, which is followed by RUN.
- R6: An enabled interrupt or a reset request present on the strobe cycle or during ENTERING is held as pending. IDLE then lasts exactly one cycle before WAKE, with the held cause.
- R7: In WAKE with an interrupt cause, `resume_vec`=1 if the highest priority among the enabled requests (pending or present) is strictly greater than `cpu_prio`. Otherwise `resume_next`=1. A watchdog cause gives `resume_next`=1. A reset cause gives both flags 0. Both flags are 0 outside WAKE.
- R8: `lprc_hold` equals `wdt_enable | fscm_enable` in ENTERING and IDLE, and is 0 in RUN and WAKE.
- R9: Wake sources seen in RUN have no effect: no WAKE occurs and the clock enable stays 1.
- R10: An asserted `rst_n` (low) forces RUN at once, with `cpu_clk_en`=1 and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrsav_strobe | input | 1 | Power-save instruction executed |
| pwrsav_mode | input | 1 | 1 = idle, 0 = sleep |
| irq_flag | input | NUM_IRQ | Interrupt request flags |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority of line i at [i*PRIO_W +: PRIO_W] |
| cpu_prio | input | PRIO_W | Current CPU priority |
| dev_reset | input | 1 | Synchronous device reset request |
| wdt_timeout | input | 1 | Watchdog timeout event |
| wdt_enable | input | 1 | Watchdog is enabled |
| fscm_enable | input | 1 | Fail-safe clock monitor is enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clear | output | 1 | Watchdog clear pulse on entry |
| lprc_hold | output | 1 | Keep low-power RC oscillator running while idle |
| idle_active | output | 1 | Controller is in IDLE |
| wake_valid | output | 1 | WAKE cycle |
| wake_cause | output | 3 | One-hot cause {watchdog, reset, interrupt} |
| resume_next | output | 1 | Resume at the next instruction |
| resume_vec | output | 1 | Resume at the interrupt handler |

## Verification
The collision that matters is the power-save strobe arriving in the same cycle as an enabled interrupt, and the case where the interrupt arrives during the ENTERING cycle. The bench drives a request on exactly the strobe cycle, and in a separate run on the cycle after it. It then checks that IDLE lasts one cycle and that WAKE reports an interrupt cause with the correct resume flag. The bench also puts reset and watchdog requests in the same IDLE cycle to judge the precedence order. A behavioural reference model is compared against every output on every clock.

// File: rtl/idlepc_pkg.sv
package idlepc_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_ENTERING = 2'd1,
        ST_IDLE     = 2'd2,
        ST_WAKE     = 2'd3
    } pc_state_e;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_IRQ = 0;
    localparam int CAUSE_RST = 1;
    localparam int CAUSE_WDT = 2;
endpackage

// File: rtl/irq_scan.sv
module irq_scan #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic [NUM_IRQ-1:0]        flag,
    input  logic [NUM_IRQ-1:0]        en,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output logic                      hit,
    output logic [PRIO_W-1:0]         best
);
    logic [NUM_IRQ-1:0] live;
    logic [PRIO_W-1:0]  masked [NUM_IRQ];

    assign live = flag & en;
    assign hit  = |live;

    // Each line contributes its priority only when it is both raised and enabled.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign masked[g] = live[g] ? prio[g*PRIO_W +: PRIO_W] : '0;
    end

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (masked[i] > best) best = masked[i];
        end
    end
endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter
    import idlepc_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic               pend_irq,
    input  logic [PRIO_W-1:0]  pend_prio,
    input  logic               pend_rst,
    input  logic               hit,
    input  logic [PRIO_W-1:0]  best,
    input  logic               dev_reset,
    input  logic               wdt_timeout,
    input  logic [PRIO_W-1:0]  cpu_prio,
    output logic               wake_req,
    output logic [CAUSE_W-1:0] cause,
    output logic               res_next,
    output logic               res_vec
);
    logic              irq_any;
    logic [PRIO_W-1:0] eff_prio;

    assign irq_any = pend_irq | hit;

    always_comb begin
        if (pend_irq && hit) eff_prio = (pend_prio > best) ? pend_prio : best;
        else if (pend_irq)   eff_prio = pend_prio;
        else                 eff_prio = best;
    end

    always_comb begin
        cause    = '0;
        res_next = 1'b0;
        res_vec  = 1'b0;
        if (dev_reset || pend_rst) begin
            cause[CAUSE_RST] = 1'b1;
        end else if (wdt_timeout) begin
            cause[CAUSE_WDT] = 1'b1;
            res_next         = 1'b1;
        end else if (irq_any) begin
            cause[CAUSE_IRQ] = 1'b1;
            if (eff_prio > cpu_prio) res_vec  = 1'b1;
            else                     res_next = 1'b1;
        end
        wake_req = |cause;
    end
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import idlepc_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_idle,
    input  logic               hit,
    input  logic [PRIO_W-1:0]  best,
    input  logic               dev_reset,
    input  logic               clk_keep,
    input  logic               wake_req,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               next_in,
    input  logic               vec_in,
    output logic               pend_irq,
    output logic [PRIO_W-1:0]  pend_prio,
    output logic               pend_rst,
    output logic               in_idle,
    output logic               cpu_clk_en,
    output logic               wdt_clear,
    output logic               lprc_hold,
    output logic               wake_valid,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic               resume_next,
    output logic               resume_vec
);
    pc_state_e          state, state_nx;
    logic               capture;
    logic [CAUSE_W-1:0] cause_q;
    logic               next_q, vec_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:      if (go_idle) state_nx = ST_ENTERING;
            ST_ENTERING: state_nx = ST_IDLE;
            ST_IDLE:     if (wake_req) state_nx = ST_WAKE;
            ST_WAKE:     state_nx = ST_RUN;
        endcase
    end

    // Requests that coincide with the strobe or fall in ENTERING are held.
    assign capture = (state == ST_RUN && go_idle) || (state == ST_ENTERING);
    assign in_idle = (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            pend_irq  <= 1'b0;
            pend_prio <= '0;
            pend_rst  <= 1'b0;
            cause_q   <= '0;
            next_q    <= 1'b0;
            vec_q     <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_WAKE) begin
                pend_irq  <= 1'b0;
                pend_prio <= '0;
                pend_rst  <= 1'b0;
            end else if (capture) begin
                if (hit) begin
                    pend_irq <= 1'b1;
                    if (!pend_irq || best > pend_prio) pend_prio <= best;
                end
                if (dev_reset) pend_rst <= 1'b1;
            end
            if (state == ST_IDLE && wake_req) begin
                cause_q <= cause_in;
                next_q  <= next_in;
                vec_q   <= vec_in;
            end
        end
    end

    always_comb begin
        cpu_clk_en  = 1'b1;
        wdt_clear   = 1'b0;
        lprc_hold   = 1'b0;
        wake_valid  = 1'b0;
        wake_cause  = '0;
        resume_next = 1'b0;
        resume_vec  = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_ENTERING: begin
                cpu_clk_en = 1'b0;
                wdt_clear  = 1'b1;
                lprc_hold  = clk_keep;
            end
            ST_IDLE: begin
                cpu_clk_en = 1'b0;
                lprc_hold  = clk_keep;
            end
            ST_WAKE: begin
                wake_valid  = 1'b1;
                wake_cause  = cause_q;
                resume_next = next_q;
                resume_vec  = vec_q;
            end
        endcase
    end
endmodule

// File: rtl/idle_power_ctrl.sv
module idle_power_ctrl
    import idlepc_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwrsav_strobe,
    input  logic                      pwrsav_mode,
    input  logic [NUM_IRQ-1:0]        irq_flag,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         cpu_prio,
    input  logic                      dev_reset,
    input  logic                      wdt_timeout,
    input  logic                      wdt_enable,
    input  logic                      fscm_enable,
    output logic                      cpu_clk_en,
    output logic                      wdt_clear,
    output logic                      lprc_hold,
    output logic                      idle_active,
    output logic                      wake_valid,
    output logic [2:0]                wake_cause,
    output logic                      resume_next,
    output logic                      resume_vec
);
    logic               hit, wake_req, res_next, res_vec;
    logic               pend_irq, pend_rst;
    logic [PRIO_W-1:0]  best, pend_prio;
    logic [CAUSE_W-1:0] cause;

    irq_scan #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_scan (
        .flag (irq_flag),
        .en   (irq_en),
        .prio (irq_prio),
        .hit  (hit),
        .best (best)
    );

    wake_arbiter #(.PRIO_W(PRIO_W)) u_arb (
        .pend_irq    (pend_irq),
        .pend_prio   (pend_prio),
        .pend_rst    (pend_rst),
        .hit         (hit),
        .best        (best),
        .dev_reset   (dev_reset),
        .wdt_timeout (wdt_timeout),
        .cpu_prio    (cpu_prio),
        .wake_req    (wake_req),
        .cause       (cause),
        .res_next    (res_next),
        .res_vec     (res_vec)
    );

    idle_fsm #(.PRIO_W(PRIO_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_idle     (pwrsav_strobe & pwrsav_mode),
        .hit         (hit),
        .best        (best),
        .dev_reset   (dev_reset),
        .clk_keep    (wdt_enable | fscm_enable),
        .wake_req    (wake_req),
        .cause_in    (cause),
        .next_in     (res_next),
        .vec_in      (res_vec),
        .pend_irq    (pend_irq),
        .pend_prio   (pend_prio),
        .pend_rst    (pend_rst),
        .in_idle     (idle_active),
        .cpu_clk_en  (cpu_clk_en),
        .wdt_clear   (wdt_clear),
        .lprc_hold   (lprc_hold),
        .wake_valid  (wake_valid),
        .wake_cause  (wake_cause),
        .resume_next (resume_next),
        .resume_vec  (resume_vec)
    );
endmodule

// File: rtl/idle_power_ctrl_chk.sv
module idle_power_ctrl_chk #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwrsav_strobe,
    input logic       pwrsav_mode,
    input logic       wdt_enable,
    input logic       fscm_enable,
    input logic       cpu_clk_en,
    input logic       wdt_clear,
    input logic       lprc_hold,
    input logic       idle_active,
    input logic       wake_valid,
    input logic [2:0] wake_cause,
    input logic       resume_next,
    input logic       resume_vec
);
    // R1
    idle_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_active |-> !cpu_clk_en);
    // R2
    clear_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> idle_active);
    // R3
    sleep_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !wake_valid && pwrsav_strobe && !pwrsav_mode) |=> cpu_clk_en);
    // R5
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> $countones(wake_cause) == 1);
    // R5
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid && cpu_clk_en);
    // R9
    wake_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> $past(idle_active));
    // R7
    resume_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resume_next && resume_vec));
    // R7
    resume_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_valid |-> (!resume_next && !resume_vec));
    // R8
    lprc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> (lprc_hold == (wdt_enable | fscm_enable)));
endmodule

bind idle_power_ctrl idle_power_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwrsav_strobe (pwrsav_strobe),
    .pwrsav_mode   (pwrsav_mode),
    .wdt_enable    (wdt_enable),
    .fscm_enable   (fscm_enable),
    .cpu_clk_en    (cpu_clk_en),
    .wdt_clear     (wdt_clear),
    .lprc_hold     (lprc_hold),
    .idle_active   (idle_active),
    .wake_valid    (wake_valid),
    .wake_cause    (wake_cause),
    .resume_next   (resume_next),
    .resume_vec    (resume_vec)
);

// File: tb/idle_power_ctrl_test.sv
`timescale 1ns/1ps
module idle_power_ctrl_test;
    localparam int N  = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwrsav_strobe = 0, pwrsav_mode = 0;
    logic [N-1:0]  irq_flag = '0, irq_en = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic [PW-1:0] cpu_prio = '0;
    logic          dev_reset = 0, wdt_timeout = 0, wdt_enable = 0, fscm_enable = 0;
    logic          cpu_clk_en, wdt_clear, lprc_hold, idle_active, wake_valid;
    logic [2:0]    wake_cause;
    logic          resume_next, resume_vec;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // reference model state: 0 run, 1 entering, 2 idle, 3 wake
    int m_st = 0;
    bit m_pi = 0, m_pr = 0;
    int m_pp = 0;
    int m_cause = 0;
    bit m_next = 0, m_vec = 0;

    always #4 clk = ~clk;

    idle_power_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .pwrsav_strobe(pwrsav_strobe), .pwrsav_mode(pwrsav_mode),
        .irq_flag(irq_flag), .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
        .dev_reset(dev_reset), .wdt_timeout(wdt_timeout), .wdt_enable(wdt_enable),
        .fscm_enable(fscm_enable), .cpu_clk_en(cpu_clk_en), .wdt_clear(wdt_clear),
        .lprc_hold(lprc_hold), .idle_active(idle_active), .wake_valid(wake_valid),
        .wake_cause(wake_cause), .resume_next(resume_next), .resume_vec(resume_vec)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int top_prio(output bit any);
        int b = 0;
        any = 0;
        for (int i = 0; i < N; i++) begin
            if (irq_flag[i] && irq_en[i]) begin
                any = 1;
                if (int'(irq_prio[i*PW +: PW]) > b) b = int'(irq_prio[i*PW +: PW]);
            end
        end
        return b;
    endfunction

    task automatic model_capture();
        bit any;
        int b;
        b = top_prio(any);
        if (any) begin
            if (!m_pi || b > m_pp) m_pp = b;
            m_pi = 1;
        end
        if (dev_reset) m_pr = 1;
    endtask

    task automatic model_step();
        bit any;
        int b;
        case (m_st)
            0: if (pwrsav_strobe && pwrsav_mode) begin model_capture(); m_st = 1; end
            1: begin model_capture(); m_st = 2; end
            2: begin
                b = top_prio(any);
                if (m_pi && (!any || m_pp > b)) b = m_pp;
                any = any || m_pi;
                if (dev_reset || m_pr) begin
                    m_cause = 2; m_next = 0; m_vec = 0; m_st = 3;
                end else if (wdt_timeout) begin
                    m_cause = 4; m_next = 1; m_vec = 0; m_st = 3;
                end else if (any) begin
                    m_cause = 1;
                    m_vec = (b > int'(cpu_prio));
                    m_next = !m_vec;
                    m_st = 3;
                end
            end
            default: begin m_pi = 0; m_pr = 0; m_pp = 0; m_st = 0; end
        endcase
    endtask

    task automatic model_reset();
        m_st = 0; m_pi = 0; m_pr = 0; m_pp = 0; m_cause = 0; m_next = 0; m_vec = 0;
    endtask

    task automatic compare_all();
        check("R1 cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0 || m_st == 3));
        check("R1 idle_active", int'(idle_active), int'(m_st == 2));
        check("R2 wdt_clear", int'(wdt_clear), int'(m_st == 1));
        check("R8 lprc_hold", int'(lprc_hold), int'((m_st == 1 || m_st == 2) && (wdt_enable || fscm_enable)));
        check("R5 wake_valid", int'(wake_valid), int'(m_st == 3));
        check("R5 wake_cause", int'(wake_cause), (m_st == 3) ? m_cause : 0);
        check("R7 resume_next", int'(resume_next), int'(m_st == 3 && m_next));
        check("R7 resume_vec", int'(resume_vec), int'(m_st == 3 && m_vec));
    endtask

    // one clock: model advances on the edge, outputs compared at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic quiet();
        pwrsav_strobe = 0; pwrsav_mode = 0; irq_flag = '0;
        dev_reset = 0; wdt_timeout = 0;
    endtask

    task automatic set_prio(input int line, input int p);
        irq_prio[line*PW +: PW] = PW'(p);
    endtask

    task automatic enter_idle();
        pwrsav_strobe = 1; pwrsav_mode = 1;
        tick();
        quiet();
        tick();
    endtask

    initial begin
        for (int i = 0; i < N; i++) set_prio(i, i % 8);
        #1;
        // R10 reset state
        check("R10 clk_en in reset", int'(cpu_clk_en), 1);
        check("R10 outputs quiet in reset", int'({wdt_clear, lprc_hold, idle_active, wake_valid, wake_cause, resume_next, resume_vec}), 0);
        @(negedge clk);
        rst_n = 1;
        compare_all();

        // R3 sleep selector ignored
        pwrsav_strobe = 1; pwrsav_mode = 0;
        tick(); quiet(); tick();
        check("R3 sleep strobe stays in run", int'(cpu_clk_en && !idle_active), 1);

        // R9 wake sources in run
        irq_en = 8'hFF; irq_flag = 8'h10; dev_reset = 1; wdt_timeout = 1;
        tick(); tick(); quiet();
        check("R9 no wake from run", int'(wake_valid), 0);

        // R4 high priority enabled interrupt -> handler
        cpu_prio = 3; wdt_enable = 1;
        enter_idle();
        check("R1 in idle", int'(idle_active), 1);
        tick(); tick();
        irq_flag = 8'h20;               // line 5, prio 5 > 3
        tick(); quiet();
        check("R4 wake on enabled irq", int'(wake_valid), 1);
        check("R7 vector resume", int'(resume_vec), 1);
        tick();

        // R7 low priority -> next instruction
        wdt_enable = 0; fscm_enable = 1;
        enter_idle();
        irq_flag = 8'h04;               // line 2, prio 2 <= 3
        tick(); quiet();
        check("R7 next-instruction resume", int'(resume_next), 1);
        tick();

        // R4 disabled flag never wakes, then watchdog
        fscm_enable = 0; irq_en = 8'h0F;
        enter_idle();
        irq_flag = 8'hF0;
        tick(); tick(); tick();
        check("R4 disabled flag no wake", int'(idle_active), 1);
        wdt_timeout = 1;
        tick(); quiet();
        check("R5 watchdog cause", int'(wake_cause), 4);
        tick();

        // R5 precedence: reset over watchdog and irq
        irq_en = 8'hFF;
        enter_idle();
        dev_reset = 1; wdt_timeout = 1; irq_flag = 8'h80;
        tick(); quiet();
        check("R5 reset wins", int'(wake_cause), 2);
        tick();
        enter_idle();
        wdt_timeout = 1; irq_flag = 8'h80;
        tick(); quiet();
        check("R5 watchdog over irq", int'(wake_cause), 4);
        tick();

        // R6 interrupt coincident with strobe
        pwrsav_strobe = 1; pwrsav_mode = 1; irq_flag = 8'h40; // prio 6
        tick(); quiet();
        tick();
        check("R6 idle reached", int'(idle_active), 1);
        tick();
        check("R6 held irq wakes", int'(wake_cause), 1);
        check("R6 held irq vector", int'(resume_vec), 1);
        tick();

        // R6 interrupt during ENTERING, low priority
        cpu_prio = 7;
        pwrsav_strobe = 1; pwrsav_mode = 1;
        tick(); quiet(); irq_flag = 8'h02;
        tick(); quiet();
        tick();
        check("R6 entering irq wakes, next", int'(resume_next), 1);
        tick();

        // R6 reset request during ENTERING
        pwrsav_strobe = 1; pwrsav_mode = 1;
        tick(); quiet(); dev_reset = 1;
        tick(); quiet();
        tick();
        check("R6 held reset cause", int'(wake_cause), 2);
        tick(); tick();

        // R10 async reset while idle
        wdt_enable = 1;
        enter_idle();
        #1 rst_n = 0; model_reset();
        #1;
        check("R10 async reset clk_en", int'(cpu_clk_en), 1);
        check("R10 async reset idle cleared", int'(idle_active), 0);
        @(negedge clk); rst_n = 1;
        tick(); tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule